// File: doc/BRIEF.md
# Video Loopback Clock-Crossing FIFO

This block moves decoded video words from a receive path, clocked by the recovered parallel clock, to a transmit path that runs on its own unrelated parallel clock. The write side stores a word only while the receiver says it is locked. The read side holds back until the buffer is at least half full. It then hands one word per read clock to the transmit encoder, so the buffer runs with slack in both directions.

The two pointers cross between domains as Gray code through two-stage synchronizers. Each side derives its own fill level from its own pointer and the synchronized copy of the other pointer. A write into a full buffer is dropped and latches a sticky overflow flag on the write side. If the read side runs dry while streaming, it latches a sticky underflow flag and returns to waiting for the half-full point. A loss of lock, seen on the read side through a synchronizer, also sends the read side back to waiting. Each domain has its own synchronous active-low reset, and the two resets are applied together so that both pointers start from zero.

Top module: `vid_loop_cdc_fifo`

## Requirements
- R1: After reset, wr_level and rd_level are 0, rd_empty is 1, and wr_full, wr_overflow, rd_underflow, rd_started and rd_valid are all 0.
- R2: A word is stored only at a wr_clk edge where wr_lock and wr_valid are both 1. With wr_lock at 0, wr_valid has no effect on wr_level or on the read side.
- R3: The words leaving on rd_data, each marked by rd_valid, are exactly the stored words, in write order, with none repeated or skipped.
- R4: wr_full is 1 when wr_level equals DEPTH (default 64). A write attempted while wr_full is 1 is dropped and sets wr_overflow, which stays 1 until reset.
- R5: rd_started rises only at a rd_clk edge where rd_level is at least DEPTH/2 (default 32) and the synchronized lock is 1.
- R6: While rd_started is 1 and the buffer is not empty, one word is read at every rd_clk edge, and rd_valid is 1 in the cycle after each read. rd_valid is never 1 without a read.
- R7: A rd_clk edge with rd_started at 1 and rd_level at 0 sets the sticky rd_underflow flag and clears rd_started.
- R8: When wr_lock falls, rd_started is 0 within three rd_clk edges (two synchronizer stages plus one state register).
- R9: After rd_started has been cleared, streaming resumes only once the half-full condition of R5 holds again. Stored words are kept across the pause.
- R10: The write and read Gray pointers change by at most one bit per clock of their own domain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Receiver recovered parallel clock |
| wr_rst_n | input | 1 | Synchronous active-low reset, write domain |
| wr_lock | input | 1 | Receiver lock; writes are allowed only while 1 |
| wr_valid | input | 1 | Word present on wr_data |
| wr_data | input | DATA_W | Decoded video word |
| wr_level | output | ADDR_W+1 | Fill level as seen from the write side |
| wr_full | output | 1 | Buffer full, write side view |
| wr_overflow | output | 1 | Sticky: a write was dropped because the buffer was full |
| rd_clk | input | 1 | Transmitter parallel clock |
| rd_rst_n | input | 1 | Synchronous active-low reset, read domain |
| rd_data | output | DATA_W | Word for the transmit encoder |
| rd_valid | output | 1 | rd_data holds a freshly read word |
| rd_started | output | 1 | Read side is streaming |
| rd_level | output | ADDR_W+1 | Fill level as seen from the read side |
| rd_empty | output | 1 | Buffer empty, read side view |
| rd_underflow | output | 1 | Sticky: the read side ran dry while streaming |

## Verification
A pointer or synchronizer fault shows first as a wrong word, a repeated word or a missing word on rd_data. The bench compares every rd_valid word with its queue model in the same read cycle. A faulty read-state register shows within one read cycle: rd_valid is missing while the model says a word is due, rd_started rises below the half-full level, or an empty read leaves no underflow. Lock handling is checked by a bound of three read cycles from the lock drop to rd_started falling. Full handling is checked by the exact count of 64 accepted words and the sticky overflow flag after a burst with the read clock stopped.

// File: rtl/vlf_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the video loopback clock-crossing FIFO.
// Assumes: two-stage synchronizers are enough for the target clock rates.
package vlf_pkg;
    localparam int SYNC_STAGES = 2;

    // Read-side control state: waiting for half-full, or streaming.
    typedef enum logic {
        RD_FILL   = 1'b0,
        RD_STREAM = 1'b1
    } rd_state_e;
endpackage

// File: rtl/vlf_sync.sv
`timescale 1ns/1ps
// Multi-bit level synchronizer made of a chain of flops.
// Assumes: the input is Gray coded or a single quasi-static bit, so at most
// one bit is in flight at any time.
module vlf_sync #(
    parameter int W      = 7,
    parameter int STAGES = vlf_pkg::SYNC_STAGES
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    // Shift the asynchronous input through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/vlf_gray_dec.sv
`timescale 1ns/1ps
// Combinational Gray-to-binary decoder.
// Assumes: input is a reflected binary Gray code of width W.
module vlf_gray_dec #(
    parameter int W = 7
) (
    input  logic [W-1:0] gray,
    output logic [W-1:0] bin
);
    // Each binary bit is the parity of the Gray bits at and above it.
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign bin[i] = ^gray[W-1:i];
    end
endmodule

// File: rtl/vlf_ram.sv
`timescale 1ns/1ps
// Dual-clock storage array: written on wr_clk, registered read on rd_clk.
// Assumes: the controllers never read an address that is being written.
module vlf_ram #(
    parameter int DATA_W = 20,
    parameter int ADDR_W = 6
) (
    input  logic              wr_clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_clk,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Store an accepted word.
    always_ff @(posedge wr_clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    // Fetch the word at the read pointer when the read side consumes it.
    always_ff @(posedge rd_clk) begin
        if (rd_en) rd_data <= mem[rd_addr];
    end
endmodule

// File: rtl/vlf_wr_side.sv
`timescale 1ns/1ps
// Write-domain controller: lock-gated push, Gray write pointer, fill level,
// full detection and a sticky overflow flag.
// Assumes: rd_gray_s is the read Gray pointer already synchronized to wr_clk.
module vlf_wr_side #(
    parameter int ADDR_W = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            lock,
    input  logic            valid,
    input  logic [ADDR_W:0] rd_gray_s,
    output logic            wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [ADDR_W:0] wr_gray,
    output logic [ADDR_W:0] level,
    output logic            full,
    output logic            overflow
);
    localparam int PW    = ADDR_W + 1;
    localparam int DEPTH = 1 << ADDR_W;

    logic [PW-1:0] wr_bin;
    logic [PW-1:0] wr_bin_nxt;
    logic [PW-1:0] rd_bin_s;
    logic          push_try;

    vlf_gray_dec #(.W(PW)) u_rd_dec (
        .gray (rd_gray_s),
        .bin  (rd_bin_s)
    );

    // Level, full flag and the accepted-write strobe.
    always_comb begin
        level      = wr_bin - rd_bin_s;
        full       = (level == PW'(DEPTH));
        push_try   = lock && valid;
        wr_en      = push_try && !full;
        wr_bin_nxt = wr_bin + PW'(1);
    end

    assign wr_addr = wr_bin[ADDR_W-1:0];

    // Advance the binary and Gray pointers on accepted writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_bin  <= '0;
            wr_gray <= '0;
        end else if (wr_en) begin
            wr_bin  <= wr_bin_nxt;
            wr_gray <= wr_bin_nxt ^ (wr_bin_nxt >> 1);
        end
    end

    // Latch a write that was dropped for lack of space.
    always_ff @(posedge clk) begin
        if (!rst_n)                overflow <= 1'b0;
        else if (push_try && full) overflow <= 1'b1;
    end

    a_r2_no_write_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
        !lock |=> $stable(wr_gray));
    a_r4_no_write_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        full |=> $stable(wr_gray));
    a_r4_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);
    a_r4_level_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        level <= PW'(DEPTH));
    a_r10_wr_gray_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(wr_gray ^ $past(wr_gray)) <= 1);
endmodule

// File: rtl/vlf_rd_side.sv
`timescale 1ns/1ps
// Read-domain controller: waits for half-full with lock, then streams one
// word per clock; clears streaming on lock loss or underflow.
// Assumes: wr_gray_s and lock_s are already synchronized to rd_clk.
module vlf_rd_side #(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W:0]   wr_gray_s,
    input  logic              lock_s,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [ADDR_W:0]   rd_gray,
    output logic [ADDR_W:0]   level,
    output logic              empty,
    output logic              started,
    output logic              underflow,
    output logic              valid
);
    import vlf_pkg::*;

    localparam int PW   = ADDR_W + 1;
    localparam int HALF = 1 << (ADDR_W - 1);

    rd_state_e     state;
    logic [PW-1:0] rd_bin;
    logic [PW-1:0] rd_bin_nxt;
    logic [PW-1:0] wr_bin_s;

    vlf_gray_dec #(.W(PW)) u_wr_dec (
        .gray (wr_gray_s),
        .bin  (wr_bin_s)
    );

    // Level, empty flag and the read strobe.
    always_comb begin
        level      = wr_bin_s - rd_bin;
        empty      = (level == '0);
        started    = (state == RD_STREAM);
        rd_en      = started && !empty;
        rd_bin_nxt = rd_bin + PW'(1);
    end

    assign rd_addr = rd_bin[ADDR_W-1:0];

    // Advance the binary and Gray read pointers on each read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_bin  <= '0;
            rd_gray <= '0;
        end else if (rd_en) begin
            rd_bin  <= rd_bin_nxt;
            rd_gray <= rd_bin_nxt ^ (rd_bin_nxt >> 1);
        end
    end

    // Fill/stream state machine with sticky underflow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= RD_FILL;
            underflow <= 1'b0;
        end else begin
            case (state)
                RD_FILL: begin
                    if (lock_s && level >= PW'(HALF)) state <= RD_STREAM;
                end
                RD_STREAM: begin
                    if (empty) begin
                        underflow <= 1'b1;
                        state     <= RD_FILL;
                    end else if (!lock_s) begin
                        state     <= RD_FILL;
                    end
                end
                default: state <= RD_FILL;
            endcase
        end
    end

    // Mark the cycle in which a freshly read word sits on the output.
    always_ff @(posedge clk) begin
        if (!rst_n) valid <= 1'b0;
        else        valid <= rd_en;
    end

    a_r5_start_at_half: assert property (@(posedge clk) disable iff (!rst_n)
        !started && lock_s && level >= PW'(HALF) |=> started);
    a_r5_no_early_start: assert property (@(posedge clk) disable iff (!rst_n)
        !started && level < PW'(HALF) |=> !started);
    a_r6_read_each_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        started && !empty |=> valid);
    a_r7_underflow_stops: assert property (@(posedge clk) disable iff (!rst_n)
        started && empty |=> underflow && !started);
    a_r7_underflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |=> underflow);
    a_r8_lock_loss_stops: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_s |=> !started);
    a_r10_rd_gray_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(rd_gray ^ $past(rd_gray)) <= 1);
endmodule

// File: rtl/vid_loop_cdc_fifo.sv
`timescale 1ns/1ps
// Video loopback clock-crossing FIFO: carries receive-side words into the
// transmit clock domain, written under receiver lock, read from half-full.
// Assumes: wr_rst_n and rd_rst_n are asserted together so that both
// pointers start at zero; DEPTH = 2**ADDR_W with ADDR_W >= 2.
module vid_loop_cdc_fifo #(
    parameter int DATA_W = 20,
    parameter int ADDR_W = 6
) (
    input  logic              wr_clk,
    input  logic              wr_rst_n,
    input  logic              wr_lock,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    output logic [ADDR_W:0]   wr_level,
    output logic              wr_full,
    output logic              wr_overflow,
    input  logic              rd_clk,
    input  logic              rd_rst_n,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              rd_started,
    output logic [ADDR_W:0]   rd_level,
    output logic              rd_empty,
    output logic              rd_underflow
);
    localparam int PW = ADDR_W + 1;

    logic              ram_we;
    logic              ram_re;
    logic [ADDR_W-1:0] ram_waddr;
    logic [ADDR_W-1:0] ram_raddr;
    logic [PW-1:0]     wr_gray;
    logic [PW-1:0]     rd_gray;
    logic [PW-1:0]     wr_gray_at_rd;
    logic [PW-1:0]     rd_gray_at_wr;
    logic [0:0]        lock_at_rd;

    vlf_wr_side #(.ADDR_W(ADDR_W)) u_wr (
        .clk       (wr_clk),
        .rst_n     (wr_rst_n),
        .lock      (wr_lock),
        .valid     (wr_valid),
        .rd_gray_s (rd_gray_at_wr),
        .wr_en     (ram_we),
        .wr_addr   (ram_waddr),
        .wr_gray   (wr_gray),
        .level     (wr_level),
        .full      (wr_full),
        .overflow  (wr_overflow)
    );

    vlf_sync #(.W(PW)) u_rd2wr (
        .clk   (wr_clk),
        .rst_n (wr_rst_n),
        .d     (rd_gray),
        .q     (rd_gray_at_wr)
    );

    vlf_sync #(.W(PW)) u_wr2rd (
        .clk   (rd_clk),
        .rst_n (rd_rst_n),
        .d     (wr_gray),
        .q     (wr_gray_at_rd)
    );

    vlf_sync #(.W(1)) u_lock2rd (
        .clk   (rd_clk),
        .rst_n (rd_rst_n),
        .d     (wr_lock),
        .q     (lock_at_rd)
    );

    vlf_rd_side #(.ADDR_W(ADDR_W)) u_rd (
        .clk       (rd_clk),
        .rst_n     (rd_rst_n),
        .wr_gray_s (wr_gray_at_rd),
        .lock_s    (lock_at_rd[0]),
        .rd_en     (ram_re),
        .rd_addr   (ram_raddr),
        .rd_gray   (rd_gray),
        .level     (rd_level),
        .empty     (rd_empty),
        .started   (rd_started),
        .underflow (rd_underflow),
        .valid     (rd_valid)
    );

    vlf_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
        .wr_clk  (wr_clk),
        .wr_en   (ram_we),
        .wr_addr (ram_waddr),
        .wr_data (wr_data),
        .rd_clk  (rd_clk),
        .rd_en   (ram_re),
        .rd_addr (ram_raddr),
        .rd_data (rd_data)
    );
endmodule

// File: tb/vid_loop_cdc_fifo_tb.sv
`timescale 1ns/100ps
// Bench: queue reference model checked on every read clock; write clock
// 50 MHz, read clock period 23 ns (non-integer ratio).
module vid_loop_cdc_fifo_tb;
    localparam int DW    = 20;
    localparam int AW    = 6;
    localparam int DEPTH = 64;
    localparam int HALF  = 32;

    logic          wr_clk = 1'b0;
    logic          rd_clk = 1'b0;
    bit            rd_run = 1'b1;
    logic          wr_rst_n = 1'b0;
    logic          rd_rst_n = 1'b0;
    logic          wr_lock = 1'b0;
    logic          wr_valid = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic [AW:0]   wr_level;
    logic          wr_full;
    logic          wr_overflow;
    logic [DW-1:0] rd_data;
    logic          rd_valid;
    logic          rd_started;
    logic [AW:0]   rd_level;
    logic          rd_empty;
    logic          rd_underflow;

    vid_loop_cdc_fifo #(.DATA_W(DW), .ADDR_W(AW)) u_dut (
        .wr_clk       (wr_clk),
        .wr_rst_n     (wr_rst_n),
        .wr_lock      (wr_lock),
        .wr_valid     (wr_valid),
        .wr_data      (wr_data),
        .wr_level     (wr_level),
        .wr_full      (wr_full),
        .wr_overflow  (wr_overflow),
        .rd_clk       (rd_clk),
        .rd_rst_n     (rd_rst_n),
        .rd_data      (rd_data),
        .rd_valid     (rd_valid),
        .rd_started   (rd_started),
        .rd_level     (rd_level),
        .rd_empty     (rd_empty),
        .rd_underflow (rd_underflow)
    );

    always #10 wr_clk = ~wr_clk;
    always #11.5 begin
        if (rd_run) rd_clk = ~rd_clk;
    end

    int            compared   = 0;
    int            mismatched = 0;
    int            seq        = 1;
    int            accepted   = 0;
    logic [DW-1:0] model_q[$];
    bit            mon_en     = 1'b0;
    bit            p_started  = 1'b0;
    int            p_level    = 0;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    endtask

    // Reference model on the read side, compared at every read-clock sample.
    always @(negedge rd_clk) begin
        if (mon_en) begin
            if (rd_valid) begin
                if (model_q.size() == 0) begin
                    check(1'b0, "R3 word out with empty model", rd_data, -1);
                end else begin
                    logic [DW-1:0] exp_w;
                    exp_w = model_q.pop_front();
                    check(rd_data == exp_w, "R3 word order", rd_data, exp_w);
                end
                if (!p_started) check(1'b0, "R6 rd_valid without streaming", rd_valid, 0);
            end
            if (p_started && p_level > 0)
                check(rd_valid == 1'b1, "R6 one read per cycle", rd_valid, 1);
            if (p_started && p_level == 0)
                check(rd_underflow && !rd_started, "R7 underflow on empty read",
                      {rd_underflow, rd_started}, 2);
            if (!p_started && rd_started)
                check(rd_level >= HALF, "R5 R9 start needs half-full", rd_level, HALF);
            p_started = rd_started;
            p_level   = int'(rd_level);
        end
    end

    task automatic do_reset();
        mon_en   = 1'b0;
        rd_run   = 1'b1;
        wr_lock  = 1'b0;
        wr_valid = 1'b0;
        wr_rst_n = 1'b0;
        rd_rst_n = 1'b0;
        repeat (4) @(negedge wr_clk);
        repeat (4) @(negedge rd_clk);
        model_q.delete();
        p_started = 1'b0;
        p_level   = 0;
        accepted  = 0;
        @(negedge wr_clk);
        wr_rst_n = 1'b1;
        rd_rst_n = 1'b1;
        mon_en   = 1'b1;
    endtask

    // Drive n write cycles; with gap > 0 every gap-th cycle is idle.
    task automatic drive(input int n, input bit lock, input int gap);
        for (int i = 0; i < n; i++) begin
            @(negedge wr_clk);
            wr_lock  = lock;
            wr_valid = (gap == 0) || (i % gap != gap - 1);
            wr_data  = DW'(seq);
            if (wr_valid) seq++;
            if (wr_lock && wr_valid && !wr_full) begin
                model_q.push_back(wr_data);
                accepted++;
            end
        end
        @(negedge wr_clk);
        wr_valid = 1'b0;
    endtask

    initial begin
        #3_000_000;
        check(1'b0, "watchdog expired", 0, 1);
        summary();
        $finish;
    end

    initial begin
        do_reset();
        @(negedge wr_clk);
        @(negedge rd_clk);
        // R1: reset state
        check(wr_level == 0, "R1 wr_level", wr_level, 0);
        check(!wr_full && !wr_overflow, "R1 write flags", {wr_full, wr_overflow}, 0);
        check(rd_level == 0 && rd_empty, "R1 read level/empty", {rd_level, rd_empty}, 1);
        check(!rd_started && !rd_valid && !rd_underflow, "R1 read flags",
              {rd_started, rd_valid, rd_underflow}, 0);

        // R2: valid without lock stores nothing
        drive(20, 1'b0, 0);
        check(wr_level == 0, "R2 wr_level unlocked", wr_level, 0);
        repeat (10) @(negedge rd_clk);
        check(rd_level == 0, "R2 rd_level unlocked", rd_level, 0);
        check(!rd_started, "R2 no start unlocked", rd_started, 0);

        // R3 R5 R6 R7: gapped stream, then drain to underflow
        drive(200, 1'b1, 10);
        repeat (600) @(negedge wr_clk);
        check(model_q.size() == 0, "R3 all words delivered", model_q.size(), 0);
        check(rd_underflow == 1'b1, "R7 sticky underflow after drain", rd_underflow, 1);
        check(!rd_started, "R7 streaming cleared", rd_started, 0);
        check(!wr_overflow, "R4 no false overflow", wr_overflow, 0);

        // R8 R9: lock loss mid-stream, then relock
        do_reset();
        drive(60, 1'b1, 0);
        check(rd_started == 1'b1, "R5 streaming after half-full", rd_started, 1);
        @(negedge wr_clk);
        wr_lock  = 1'b0;
        wr_valid = 1'b1;
        repeat (4) @(negedge rd_clk);
        check(!rd_started, "R8 lock loss stops streaming", rd_started, 0);
        drive(40, 1'b0, 0);
        check(!rd_started, "R8 stays stopped while unlocked", rd_started, 0);
        check(rd_level == model_q.size(), "R9 words kept across pause",
              rd_level, model_q.size());
        drive(60, 1'b1, 0);
        repeat (600) @(negedge wr_clk);
        check(model_q.size() == 0, "R9 R3 resumed and delivered all", model_q.size(), 0);
        check(rd_underflow == 1'b1, "R7 underflow after final drain", rd_underflow, 1);

        // R4: burst into a stalled reader
        do_reset();
        rd_run = 1'b0;
        drive(70, 1'b1, 0);
        repeat (3) @(negedge wr_clk);
        check(wr_full == 1'b1, "R4 full flag", wr_full, 1);
        check(wr_level == DEPTH, "R4 level at depth", wr_level, DEPTH);
        check(wr_overflow == 1'b1, "R4 sticky overflow", wr_overflow, 1);
        check(accepted == DEPTH, "R4 accepted count", accepted, DEPTH);
        rd_run = 1'b1;
        repeat (600) @(negedge wr_clk);
        check(model_q.size() == 0, "R3 R4 stored words delivered, dropped ones not",
              model_q.size(), 0);
        check(wr_overflow == 1'b1, "R4 overflow still set", wr_overflow, 1);
        check(rd_underflow == 1'b1, "R7 underflow after burst drain", rd_underflow, 1);

        summary();
        $finish;
    end
endmodule